// File: doc/BRIEF.md
# Mixed-Width Dual-Clock FIFO Controller

This block wraps a simple dual-port memory built from 9-bit storage units and lets it run in one of two modes. In RAM mode the memory is addressed directly by the caller on each side. In FIFO mode the block generates both addresses itself, keeps write and read pointers, and reports four status flags: full, empty, almost full and almost empty.

The write port and the read port each move a whole number of 9-bit units per access. The counts are set by parameters, so the FIFO can convert widths; the default is an 18-bit write port feeding a 9-bit read port. All pointer and fill-level arithmetic is done in 9-bit units. Each side steps its own pointer by its own width, so the two sides may differ in width and may run on unrelated clocks.

Pointers cross between the clock domains in Gray code through two flip-flops each. Full and almost full are judged in the write clock domain. Empty and almost empty are judged in the read clock domain. The mode input is a static setting that is changed only while both sides are held in reset.

Top module: `mwf_fifo`

## Requirements
- R1: In FIFO mode, units come out in the order they were written. Unit k of a data word occupies bits [9k+8:9k], so the lowest unit of a word is the earliest in the stream. Read data is registered and appears one read clock after an accepted read.
- R2: In FIFO mode the user address inputs `wr_addr` and `rd_addr` have no effect on what is stored or returned.
- R3: In RAM mode, a write stores the word at unit address `wr_addr*WR_UNITS`. A read returns the word at unit address `rd_addr*RD_UNITS` one read clock later. The FIFO pointers do not move, so `empty` stays high.
- R4: A write issued while `full` is high is discarded: the write pointer does not move and the data is never read out. A FIFO holding DEPTH_U units accepts exactly DEPTH_U/WR_UNITS writes starting from empty.
- R5: A read issued while `empty` is high is discarded: the read pointer does not move and `rd_data` keeps its value.
- R6: `full` is high when fewer than WR_UNITS units are free, as seen from the write domain.
- R7: `empty` is high when fewer than RD_UNITS units are present, as seen from the read domain.
- R8: `afull` is high when the write-domain fill level in units is greater than or equal to `afull_lvl`.
- R9: `aempty` is high when the read-domain fill level in units is less than or equal to `aempty_lvl`.
- R10: An accepted write is counted in the read-domain level after two further read-clock edges. An accepted read is counted in the write-domain level after two further write-clock edges. A pointer's Gray code changes by at most one bit per edge.
- R11: Each domain has a synchronous, active-high reset that clears its pointer and synchroniser. Out of reset, `empty` and `aempty` are high and `full` and `afull` are low, provided `afull_lvl` is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous reset, write domain |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous reset, read domain |
| fifo_mode | input | 1 | 1 = FIFO with internal pointers, 0 = directly addressed RAM |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW-log2(WR_UNITS) | Word address for RAM mode writes |
| wr_data | input | 9*WR_UNITS | Write word, lowest unit first |
| afull_lvl | input | AW+1 | Almost-full threshold in units |
| full | output | 1 | No room for another write word |
| afull | output | 1 | Fill level at or above `afull_lvl` |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW-log2(RD_UNITS) | Word address for RAM mode reads |
| aempty_lvl | input | AW+1 | Almost-empty threshold in units |
| rd_data | output | 9*RD_UNITS | Registered read word |
| empty | output | 1 | Less than one read word present |
| aempty | output | 1 | Fill level at or below `aempty_lvl` |

## Verification
On every clock, the assertions check that each side's fill level stays within zero and the depth. They also check that a request refused by full or empty leaves the pointer untouched, that each Gray pointer flips at most one bit per edge, that pointers stay idle in RAM mode, and that reset clears them. Data order, width packing, the two-edge crossing delay, the exact flag thresholds and the fact that user addresses are ignored in FIFO mode can only be shown by the bench's scenarios. The bench compares each of these against its own queue-based model on every cycle.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
    localparam int UNIT_W = 9;
    typedef logic [UNIT_W-1:0] unit_t;
endpackage

// File: rtl/mwf_sync.sv
module mwf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign q = st_q.s2;
endmodule

// File: rtl/mwf_ram.sv
module mwf_ram
    import mwf_pkg::*;
#(
    parameter int DEPTH_U  = 512,
    parameter int WR_UNITS = 2,
    parameter int RD_UNITS = 1,
    localparam int AW = $clog2(DEPTH_U)
) (
    input  logic                       wclk,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [WR_UNITS*UNIT_W-1:0] wdata,
    input  logic                       rclk,
    input  logic                       rrst,
    input  logic                       re,
    input  logic [AW-1:0]              raddr,
    output logic [RD_UNITS*UNIT_W-1:0] rdata
);
    unit_t mem [DEPTH_U];

    always_ff @(posedge wclk) begin
        if (we) begin
            for (int u = 0; u < WR_UNITS; u++) begin
                mem[waddr + AW'(u)] <= wdata[u*UNIT_W +: UNIT_W];
            end
        end
    end

    logic [RD_UNITS*UNIT_W-1:0] word_rd, rd_d, rd_q;

    always_comb begin
        for (int u = 0; u < RD_UNITS; u++) begin
            word_rd[u*UNIT_W +: UNIT_W] = mem[raddr + AW'(u)];
        end
        rd_d = rd_q;
        if (re)   rd_d = word_rd;
        if (rrst) rd_d = '0;
    end

    always_ff @(posedge rclk) rd_q <= rd_d;

    assign rdata = rd_q;
endmodule

// File: rtl/mwf_side.sv
module mwf_side #(
    parameter int DEPTH_U    = 512,
    parameter int OWN_UNITS  = 2,
    parameter int PEER_UNITS = 1,
    parameter bit IS_WR      = 1'b1,
    localparam int AW  = $clog2(DEPTH_U),
    localparam int PW  = AW + 1,
    localparam int OSH = $clog2(OWN_UNITS),
    localparam int PSH = $clog2(PEER_UNITS),
    localparam int OCW = PW - OSH,
    localparam int PCW = PW - PSH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fifo_mode,
    input  logic           req,
    input  logic [PCW-1:0] peer_gray,
    input  logic [PW-1:0]  thr,
    output logic [OCW-1:0] own_gray,
    output logic [AW-1:0]  ptr,
    output logic           fire,
    output logic           blocked,
    output logic           near
);
    typedef struct packed {
        logic [OCW-1:0] bin;
        logic [OCW-1:0] gray;
    } side_t;

    side_t st_d, st_q;
    logic [PCW-1:0] peer_bin;
    logic [PW-1:0]  own_u, peer_u, level;
    logic           step;

    // pointer positions in 9-bit units and the fill level seen here
    always_comb begin
        for (int i = 0; i < PCW; i++) begin
            peer_bin[i] = ^(peer_gray >> i);
        end
        own_u  = PW'(st_q.bin) << OSH;
        peer_u = PW'(peer_bin) << PSH;
        level  = IS_WR ? (own_u - peer_u) : (peer_u - own_u);
    end

    generate
        if (IS_WR) begin : g_wr_flags
            assign blocked = level > PW'(DEPTH_U - OWN_UNITS);
            assign near    = level >= thr;
        end else begin : g_rd_flags
            assign blocked = level < PW'(OWN_UNITS);
            assign near    = level <= thr;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        step = fifo_mode && req && !blocked;
        if (step) begin
            st_d.bin  = st_q.bin + OCW'(1);
            st_d.gray = st_d.bin ^ (st_d.bin >> 1);
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign own_gray = st_q.gray;
    assign ptr      = own_u[AW-1:0];
    assign fire     = step;

    generate
        if (IS_WR) begin : g_wr_chk
            p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
                level <= PW'(DEPTH_U));
            p_full_holds_r4: assert property (@(posedge clk) disable iff (rst)
                (fifo_mode && req && blocked) |=> $stable(st_q.bin));
        end else begin : g_rd_chk
            p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
                level <= PW'(DEPTH_U));
            p_empty_holds_r5: assert property (@(posedge clk) disable iff (rst)
                (fifo_mode && req && blocked) |=> $stable(st_q.bin));
        end
    endgenerate

    p_gray_one_bit_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_q.gray ^ $past(st_q.gray)));
    p_ram_mode_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode |=> $stable(st_q.bin));
    p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.bin == '0 && st_q.gray == '0));
endmodule

// File: rtl/mwf_fifo.sv
module mwf_fifo
    import mwf_pkg::*;
#(
    parameter int DEPTH_U  = 512,
    parameter int WR_UNITS = 2,
    parameter int RD_UNITS = 1,
    localparam int AW  = $clog2(DEPTH_U),
    localparam int PW  = AW + 1,
    localparam int WSH = $clog2(WR_UNITS),
    localparam int RSH = $clog2(RD_UNITS),
    localparam int WCW = PW - WSH,
    localparam int RCW = PW - RSH,
    localparam int WAW = AW - WSH,
    localparam int RAW = AW - RSH
) (
    input  logic                       wr_clk,
    input  logic                       wr_rst,
    input  logic                       rd_clk,
    input  logic                       rd_rst,
    input  logic                       fifo_mode,
    input  logic                       wr_en,
    input  logic [WAW-1:0]             wr_addr,
    input  logic [WR_UNITS*UNIT_W-1:0] wr_data,
    input  logic [PW-1:0]              afull_lvl,
    output logic                       full,
    output logic                       afull,
    input  logic                       rd_en,
    input  logic [RAW-1:0]             rd_addr,
    input  logic [PW-1:0]              aempty_lvl,
    output logic [RD_UNITS*UNIT_W-1:0] rd_data,
    output logic                       empty,
    output logic                       aempty
);
    logic [WCW-1:0] wgray, wgray_at_rd;
    logic [RCW-1:0] rgray, rgray_at_wr;
    logic [AW-1:0]  wptr, rptr, ram_wa, ram_ra;
    logic           wfire, rfire, ram_we, ram_re;

    mwf_side #(
        .DEPTH_U(DEPTH_U), .OWN_UNITS(WR_UNITS), .PEER_UNITS(RD_UNITS), .IS_WR(1'b1)
    ) u_wside (
        .clk(wr_clk), .rst(wr_rst), .fifo_mode(fifo_mode), .req(wr_en),
        .peer_gray(rgray_at_wr), .thr(afull_lvl), .own_gray(wgray), .ptr(wptr),
        .fire(wfire), .blocked(full), .near(afull)
    );

    mwf_side #(
        .DEPTH_U(DEPTH_U), .OWN_UNITS(RD_UNITS), .PEER_UNITS(WR_UNITS), .IS_WR(1'b0)
    ) u_rside (
        .clk(rd_clk), .rst(rd_rst), .fifo_mode(fifo_mode), .req(rd_en),
        .peer_gray(wgray_at_rd), .thr(aempty_lvl), .own_gray(rgray), .ptr(rptr),
        .fire(rfire), .blocked(empty), .near(aempty)
    );

    mwf_sync #(.W(WCW)) u_w2r (.clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_at_rd));
    mwf_sync #(.W(RCW)) u_r2w (.clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_at_wr));

    // address and strobe selection between caller and internal pointers
    always_comb begin
        ram_wa = fifo_mode ? wptr  : (AW'(wr_addr) << WSH);
        ram_ra = fifo_mode ? rptr  : (AW'(rd_addr) << RSH);
        ram_we = fifo_mode ? wfire : wr_en;
        ram_re = fifo_mode ? rfire : rd_en;
    end

    mwf_ram #(.DEPTH_U(DEPTH_U), .WR_UNITS(WR_UNITS), .RD_UNITS(RD_UNITS)) u_ram (
        .wclk(wr_clk), .we(ram_we), .waddr(ram_wa), .wdata(wr_data),
        .rclk(rd_clk), .rrst(rd_rst), .re(ram_re), .raddr(ram_ra), .rdata(rd_data)
    );
endmodule

// File: tb/tb_mwf_fifo.sv
`timescale 1ns/1ps
module tb_mwf_fifo;
    localparam int DEPTH = 512;
    localparam int WU = 2;
    localparam int RU = 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, mode, wen, ren, full, afull, empty, aempty;
    logic [7:0]  waddr;
    logic [8:0]  raddr;
    logic [17:0] wdata;
    logic [9:0]  afth, aeth;
    logic [8:0]  rdata;

    mwf_fifo #(.DEPTH_U(DEPTH), .WR_UNITS(WU), .RD_UNITS(RU)) dut (
        .wr_clk(clk), .wr_rst(rst), .rd_clk(clk), .rd_rst(rst), .fifo_mode(mode),
        .wr_en(wen), .wr_addr(waddr), .wr_data(wdata), .afull_lvl(afth),
        .full(full), .afull(afull), .rd_en(ren), .rd_addr(raddr),
        .aempty_lvl(aeth), .rd_data(rdata), .empty(empty), .aempty(aempty)
    );

    int checks = 0;
    int fails  = 0;
    int wtot, rtot, ws1, ws2, rs1, rs2;
    logic [8:0] q[$];
    logic [8:0] ramm [DEPTH];
    logic [8:0] exp_rd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: unit queue plus totals delayed by two edges
    always @(posedge clk) begin
        int wl, rl, dw, dr;
        if (rst) begin
            wtot = 0; rtot = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
            q.delete();
            exp_rd = '0;
        end else begin
            wl = wtot - rs2;
            rl = ws2 - rtot;
            dw = 0; dr = 0;
            if (mode) begin
                if (ren && rl >= RU) begin
                    for (int u = 0; u < RU; u++) exp_rd[u*9 +: 9] = q.pop_front();
                    dr = RU;
                end
                if (wen && wl <= DEPTH - WU) begin
                    for (int u = 0; u < WU; u++) q.push_back(wdata[u*9 +: 9]);
                    dw = WU;
                end
            end else begin
                if (ren) for (int u = 0; u < RU; u++) exp_rd[u*9 +: 9] = ramm[int'(raddr)*RU + u];
                if (wen) for (int u = 0; u < WU; u++) ramm[int'(waddr)*WU + u] = wdata[u*9 +: 9];
            end
            ws2 = ws1; ws1 = wtot; rs2 = rs1; rs1 = rtot;
            wtot += dw; rtot += dr;
        end
    end

    always @(negedge clk) begin
        int wl, rl;
        if (rst === 1'b0) begin
            wl = wtot - rs2;
            rl = ws2 - rtot;
            chk("R6 full", 32'(full), 32'(wl > DEPTH - WU));
            chk("R7 empty", 32'(empty), 32'(rl < RU));
            chk("R8 afull", 32'(afull), 32'(wl >= int'(afth)));
            chk("R9 aempty", 32'(aempty), 32'(rl <= int'(aeth)));
            chk(mode ? "R1 R2 rd_data" : "R3 rd_data", 32'(rdata), 32'(exp_rd));
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int nacc;
        rst = 1'b1; mode = 1'b0; wen = 1'b0; ren = 1'b0;
        waddr = '0; raddr = '0; wdata = '0; afth = 10'd400; aeth = 10'd4;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 empty", 32'(empty), 32'd1);
        chk("R11 aempty", 32'(aempty), 32'd1);
        chk("R11 full", 32'(full), 32'd0);
        chk("R11 afull", 32'(afull), 32'd0);

        // RAM mode: direct addressing
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); wen = 1'b1; waddr = 8'(i*3); wdata = 18'($urandom);
        end
        @(negedge clk); wen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ren = 1'b1; raddr = 9'(i*6 + (i % 2));
        end
        @(negedge clk); ren = 1'b0;
        chk("R3 empty stays", 32'(empty), 32'd1);
        chk("R3 full stays", 32'(full), 32'd0);

        // switch to FIFO mode under reset
        rst = 1'b1; mode = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // crossing delay of a single write
        @(negedge clk); wen = 1'b1; wdata = 18'h2A5C3;
        @(negedge clk); wen = 1'b0;
        chk("R10 empty edge1", 32'(empty), 32'd1);
        @(negedge clk);
        chk("R10 empty edge2", 32'(empty), 32'd1);
        @(negedge clk);
        chk("R10 empty edge3", 32'(empty), 32'd0);

        // narrow reads of one wide word, then reads while empty
        ren = 1'b1;
        @(negedge clk);
        chk("R1 low unit first", 32'(rdata), 32'h1C3);
        @(negedge clk);
        chk("R1 high unit second", 32'(rdata), 32'h152);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R5 rd_data holds", 32'(rdata), 32'h152);
            chk("R5 empty", 32'(empty), 32'd1);
        end
        ren = 1'b0;
        repeat (4) @(negedge clk);

        // fill past full
        nacc = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            wen = 1'b1; wdata = 18'($urandom); waddr = 8'($urandom);
            if (!full) nacc++;
        end
        @(negedge clk); wen = 1'b0;
        chk("R4 writes accepted", 32'(nacc), 32'(DEPTH / WU));
        chk("R6 full at capacity", 32'(full), 32'd1);
        chk("R8 afull at capacity", 32'(afull), 32'd1);
        repeat (3) @(negedge clk);

        // drain
        nacc = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            ren = 1'b1; raddr = 9'($urandom);
            if (!empty) nacc++;
        end
        @(negedge clk); ren = 1'b0;
        chk("R4 units read back", 32'(nacc), 32'(DEPTH / RU));
        chk("R7 empty after drain", 32'(empty), 32'd1);
        chk("R9 aempty after drain", 32'(aempty), 32'd1);

        // mixed random traffic with random user addresses
        for (int w = 0; w < 8; w++) begin
            int pw, pr;
            pw = $urandom_range(20, 90);
            pr = $urandom_range(20, 90);
            afth = 10'($urandom_range(1, 512));
            aeth = 10'($urandom_range(0, 511));
            for (int c = 0; c < 500; c++) begin
                @(negedge clk);
                wen = ($urandom_range(0, 99) < pw);
                ren = ($urandom_range(0, 99) < pr);
                wdata = 18'($urandom);
                waddr = 8'($urandom);
                raddr = 9'($urandom);
            end
        end
        @(negedge clk); wen = 1'b0; ren = 1'b0;
        repeat (5) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule